// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block steps a small microcontroller through run, sleep, stop and standby, and drives the clock-gate and oscillator enables that follow from the current mode. Software supplies a mode request strobe with a mode code, gate bits for the flash and RAM interfaces, one clock enable per APB peripheral, and gate bits for the peripheral bus and DMA clocks. The flash programmer and the APB domain report busy flags. An entry into stop or standby made while either flag is set waits in a pending state until both flags are clear.

Every output is a register that takes its next value from the next state and the current inputs. An output therefore changes on the same clock edge that samples its cause. Sleep stops only the core clock. Stop and standby switch off the oscillators, the PLL, the core power domain and every gated clock, unless the matching debug hold bit is set. An interrupt ends sleep and stop. Only reset ends standby. Leaving stop forces the internal RC oscillator as the system clock. The AHB-to-APB bridge clock drops by itself once no APB peripheral clock is enabled.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While rst_ni is low, every clock and oscillator enable and core_pwr_en_o are 1 and sysclk_sel_o is 0 (internal RC). Codes for sysclk_sel_o: 0 RC, 1 crystal, 2 PLL.
- R2: A mode_go_i pulse with mode_sel_i=1 (sleep; 0 run, 2 stop, 3 standby) clears cpu_clk_en_o at that edge. While in sleep, flash_clk_en_o and ram_clk_en_o follow flash_sw_en_i and ram_sw_en_i, and core_pwr_en_o stays 1.
- R3: One edge after every bit of apb_periph_en_i is 0, bridge_clk_en_o is 0. It returns to 1 one edge after any bit is set.
- R4: In stop or standby without a debug hold, pll_en_o, rc_main_en_o, rc_14m_en_o, xtal_en_o, core_pwr_en_o and cpu_clk_en_o are 0.
- R5: A stop or standby request made while flash_busy_i is 1 keeps all enables on until the edge that samples flash_busy_i at 0.
- R6: A stop or standby request made while apb_busy_i is 1 is held in the same way until apb_busy_i is 0.
- R7: In stop, wake_irq_i returns the controller to run at the next edge, with every enable at 1 and sysclk_sel_o at 0.
- R8: In standby, wake_irq_i has no effect. Only rst_ni leaves standby.
- R9: With dbg_stop_hold_i set in stop, or dbg_stdby_hold_i set in standby, all enables and core_pwr_en_o stay at 1.
- R10: pbus_sw_en_i=0 clears pbus_clk_en_o and dma_sw_en_i=0 clears dma_clk_en_o one edge later, in any mode.
- R11: In sleep, wake_irq_i sets cpu_clk_en_o at the next edge and leaves sysclk_sel_o unchanged.
- R12: sel_load_i loads sel_req_i into sysclk_sel_o only in run. In other states it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_go_i | input | 1 | Mode request strobe |
| mode_sel_i | input | 2 | Requested mode: 0 run, 1 sleep, 2 stop, 3 standby |
| sel_load_i | input | 1 | Load system clock select |
| sel_req_i | input | 2 | Requested system clock source |
| flash_sw_en_i | input | 1 | Flash interface clock kept in sleep |
| ram_sw_en_i | input | 1 | RAM interface clock kept in sleep |
| apb_periph_en_i | input | N_APB | Per-peripheral APB clock enables |
| pbus_sw_en_i | input | 1 | Peripheral bus clock software enable |
| dma_sw_en_i | input | 1 | DMA clock software enable |
| flash_busy_i | input | 1 | Flash programming in progress |
| apb_busy_i | input | 1 | APB transfer in progress |
| wake_irq_i | input | 1 | Wake interrupt |
| dbg_stop_hold_i | input | 1 | Keep clocks on in stop |
| dbg_stdby_hold_i | input | 1 | Keep clocks on in standby |
| cpu_clk_en_o | output | 1 | Core clock enable |
| flash_clk_en_o | output | 1 | Flash interface clock enable |
| ram_clk_en_o | output | 1 | RAM interface clock enable |
| bridge_clk_en_o | output | 1 | AHB-to-APB bridge clock enable |
| pbus_clk_en_o | output | 1 | Peripheral bus clock enable |
| dma_clk_en_o | output | 1 | DMA clock enable |
| pll_en_o | output | 1 | PLL enable |
| rc_main_en_o | output | 1 | Main internal RC oscillator enable |
| rc_14m_en_o | output | 1 | 14 MHz internal RC oscillator enable |
| xtal_en_o | output | 1 | External crystal oscillator enable |
| core_pwr_en_o | output | 1 | Core power domain enable |
| sysclk_sel_o | output | 2 | System clock source select |

## Verification
The pending path is the hardest to reach. A deep request only waits if a busy flag is already high at the edge that samples mode_go_i. The stimulus raises flash_busy_i or apb_busy_i first, issues the request and holds the flag for several cycles. Each of those cycles confirms that the power and oscillator enables stay on. The flag is then dropped, and the bench checks that the enables fall at the very edge that samples it low. Standby is left only by a mid-run reset. The bench sets a non-RC clock source beforehand, so the return of the reset value can be seen.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned SYSCLK_W = 2;
  localparam int unsigned N_OSC    = 4;

  localparam logic [MODE_W-1:0] MODE_RUN   = 2'd0;
  localparam logic [MODE_W-1:0] MODE_SLEEP = 2'd1;
  localparam logic [MODE_W-1:0] MODE_STOP  = 2'd2;
  localparam logic [MODE_W-1:0] MODE_STDBY = 2'd3;

  localparam logic [SYSCLK_W-1:0] SYSCLK_RC = 2'd0;

  // oscillator enable bit positions
  localparam int unsigned OSC_PLL  = 0;
  localparam int unsigned OSC_RC   = 1;
  localparam int unsigned OSC_RC14 = 2;
  localparam int unsigned OSC_XTAL = 3;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_PEND  = 3'd2,
    ST_STOP  = 3'd3,
    ST_STDBY = 3'd4
  } lpm_state_e;
endpackage

// File: rtl/lpm_apb_idle.sv
module lpm_apb_idle #(
  parameter int unsigned N_APB = 8
) (
  input  logic [N_APB-1:0] en_i,
  output logic             all_off_o
);
  logic [N_APB:0] any_on;
  assign any_on[0] = 1'b0;
  for (genvar g = 0; g < N_APB; g++) begin : g_or
    assign any_on[g+1] = any_on[g] | en_i[g];
  end
  assign all_off_o = ~any_on[N_APB];
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_go_i,
  input  logic [MODE_W-1:0]   mode_sel_i,
  input  logic                sel_load_i,
  input  logic [SYSCLK_W-1:0] sel_req_i,
  input  logic                flash_busy_i,
  input  logic                apb_busy_i,
  input  logic                wake_irq_i,
  output lpm_state_e          state_q_o,
  output lpm_state_e          state_d_o,
  output logic [SYSCLK_W-1:0] sysclk_sel_o
);
  lpm_state_e          state_q, state_d;
  logic                pend_stdby_q, pend_stdby_d;
  logic [SYSCLK_W-1:0] sel_q, sel_d;
  logic                busy;

  assign busy = flash_busy_i | apb_busy_i;

  always_comb begin
    state_d      = state_q;
    pend_stdby_d = pend_stdby_q;
    sel_d        = sel_q;
    unique case (state_q)
      ST_RUN: begin
        if (sel_load_i) sel_d = sel_req_i;
        if (mode_go_i) begin
          if (mode_sel_i == MODE_SLEEP) begin
            state_d = ST_SLEEP;
          end else if (mode_sel_i == MODE_STOP || mode_sel_i == MODE_STDBY) begin
            pend_stdby_d = (mode_sel_i == MODE_STDBY);
            if (busy)                         state_d = ST_PEND;
            else if (mode_sel_i == MODE_STDBY) state_d = ST_STDBY;
            else                              state_d = ST_STOP;
          end
        end
      end
      ST_SLEEP: if (wake_irq_i) state_d = ST_RUN;
      ST_PEND: begin
        if (!busy) state_d = pend_stdby_q ? ST_STDBY : ST_STOP;
      end
      ST_STOP: begin
        if (wake_irq_i) begin
          state_d = ST_RUN;
          sel_d   = SYSCLK_RC;
        end
      end
      ST_STDBY: state_d = ST_STDBY;  // exit by reset only
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RUN;
      pend_stdby_q <= 1'b0;
      sel_q        <= SYSCLK_RC;
    end else begin
      state_q      <= state_d;
      pend_stdby_q <= pend_stdby_d;
      sel_q        <= sel_d;
    end
  end

  assign state_q_o    = state_q;
  assign state_d_o    = state_d;
  assign sysclk_sel_o = sel_q;
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lpm_state_e       state_d_i,
  input  logic             dbg_stop_hold_i,
  input  logic             dbg_stdby_hold_i,
  input  logic             flash_sw_en_i,
  input  logic             ram_sw_en_i,
  input  logic             pbus_sw_en_i,
  input  logic             dma_sw_en_i,
  input  logic             apb_all_off_i,
  output logic             cpu_clk_en_o,
  output logic             flash_clk_en_o,
  output logic             ram_clk_en_o,
  output logic             bridge_clk_en_o,
  output logic             pbus_clk_en_o,
  output logic             dma_clk_en_o,
  output logic [N_OSC-1:0] osc_en_o,
  output logic             core_pwr_en_o
);
  logic sleep_n, held, pwr_off;

  assign sleep_n = (state_d_i == ST_SLEEP);
  assign held    = (state_d_i == ST_STOP  && dbg_stop_hold_i) ||
                   (state_d_i == ST_STDBY && dbg_stdby_hold_i);
  assign pwr_off = (state_d_i == ST_STOP || state_d_i == ST_STDBY) && !held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_clk_en_o    <= 1'b1;
      flash_clk_en_o  <= 1'b1;
      ram_clk_en_o    <= 1'b1;
      bridge_clk_en_o <= 1'b1;
      pbus_clk_en_o   <= 1'b1;
      dma_clk_en_o    <= 1'b1;
      core_pwr_en_o   <= 1'b1;
    end else begin
      cpu_clk_en_o    <= !pwr_off && !sleep_n;
      flash_clk_en_o  <= !pwr_off && (!sleep_n || flash_sw_en_i);
      ram_clk_en_o    <= !pwr_off && (!sleep_n || ram_sw_en_i);
      bridge_clk_en_o <= !pwr_off && !apb_all_off_i;
      pbus_clk_en_o   <= !pwr_off && pbus_sw_en_i;
      dma_clk_en_o    <= !pwr_off && dma_sw_en_i;
      core_pwr_en_o   <= !pwr_off;
    end
  end

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) osc_en_o[g] <= 1'b1;
      else         osc_en_o[g] <= !pwr_off;
    end
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned N_APB = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_go_i,
  input  logic [1:0]          mode_sel_i,
  input  logic                sel_load_i,
  input  logic [1:0]          sel_req_i,
  input  logic                flash_sw_en_i,
  input  logic                ram_sw_en_i,
  input  logic [N_APB-1:0]    apb_periph_en_i,
  input  logic                pbus_sw_en_i,
  input  logic                dma_sw_en_i,
  input  logic                flash_busy_i,
  input  logic                apb_busy_i,
  input  logic                wake_irq_i,
  input  logic                dbg_stop_hold_i,
  input  logic                dbg_stdby_hold_i,
  output logic                cpu_clk_en_o,
  output logic                flash_clk_en_o,
  output logic                ram_clk_en_o,
  output logic                bridge_clk_en_o,
  output logic                pbus_clk_en_o,
  output logic                dma_clk_en_o,
  output logic                pll_en_o,
  output logic                rc_main_en_o,
  output logic                rc_14m_en_o,
  output logic                xtal_en_o,
  output logic                core_pwr_en_o,
  output logic [1:0]          sysclk_sel_o
);
  lpm_state_e       state_q, state_d;
  logic             apb_all_off;
  logic [N_OSC-1:0] osc_en;

  lpm_apb_idle #(.N_APB(N_APB)) u_apb_idle (
    .en_i      (apb_periph_en_i),
    .all_off_o (apb_all_off)
  );

  lpm_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_go_i    (mode_go_i),
    .mode_sel_i   (mode_sel_i),
    .sel_load_i   (sel_load_i),
    .sel_req_i    (sel_req_i),
    .flash_busy_i (flash_busy_i),
    .apb_busy_i   (apb_busy_i),
    .wake_irq_i   (wake_irq_i),
    .state_q_o    (state_q),
    .state_d_o    (state_d),
    .sysclk_sel_o (sysclk_sel_o)
  );

  lpm_gate u_gate (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .state_d_i        (state_d),
    .dbg_stop_hold_i  (dbg_stop_hold_i),
    .dbg_stdby_hold_i (dbg_stdby_hold_i),
    .flash_sw_en_i    (flash_sw_en_i),
    .ram_sw_en_i      (ram_sw_en_i),
    .pbus_sw_en_i     (pbus_sw_en_i),
    .dma_sw_en_i      (dma_sw_en_i),
    .apb_all_off_i    (apb_all_off),
    .cpu_clk_en_o     (cpu_clk_en_o),
    .flash_clk_en_o   (flash_clk_en_o),
    .ram_clk_en_o     (ram_clk_en_o),
    .bridge_clk_en_o  (bridge_clk_en_o),
    .pbus_clk_en_o    (pbus_clk_en_o),
    .dma_clk_en_o     (dma_clk_en_o),
    .osc_en_o         (osc_en),
    .core_pwr_en_o    (core_pwr_en_o)
  );

  assign pll_en_o     = osc_en[OSC_PLL];
  assign rc_main_en_o = osc_en[OSC_RC];
  assign rc_14m_en_o  = osc_en[OSC_RC14];
  assign xtal_en_o    = osc_en[OSC_XTAL];
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int unsigned N_APB = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_APB-1:0] apb_periph_en_i,
  input logic             pbus_sw_en_i,
  input logic             flash_sw_en_i,
  input logic             flash_busy_i,
  input logic             apb_busy_i,
  input logic             wake_irq_i,
  input logic             cpu_clk_en_o,
  input logic             flash_clk_en_o,
  input logic             bridge_clk_en_o,
  input logic             pbus_clk_en_o,
  input logic             pll_en_o,
  input logic             xtal_en_o,
  input logic             core_pwr_en_o,
  input logic [1:0]       sysclk_sel_o,
  input lpm_state_e       state_q
);
  AST_SLEEP_FLASH_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && core_pwr_en_o) |-> (flash_clk_en_o == $past(flash_sw_en_i))); // R2
  AST_BRIDGE_AUTO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apb_periph_en_i == '0) |=> !bridge_clk_en_o); // R3
  AST_DEEP_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_pwr_en_o |-> (!pll_en_o && !xtal_en_o && !cpu_clk_en_o)); // R4
  AST_FLASH_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_busy_i && (state_q == ST_RUN || state_q == ST_PEND))
      |=> (state_q != ST_STOP && state_q != ST_STDBY)); // R5
  AST_APB_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apb_busy_i && (state_q == ST_RUN || state_q == ST_PEND))
      |=> (state_q != ST_STOP && state_q != ST_STDBY)); // R6
  AST_STOP_WAKE_RC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && wake_irq_i) |=> (sysclk_sel_o == SYSCLK_RC && state_q == ST_RUN)); // R7
  AST_STDBY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STDBY) |=> (state_q == ST_STDBY)); // R8
  AST_PBUS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pbus_sw_en_i |=> !pbus_clk_en_o); // R10
  AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && wake_irq_i) |=> (cpu_clk_en_o && $stable(sysclk_sel_o))); // R11
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.N_APB(N_APB)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .apb_periph_en_i (apb_periph_en_i),
  .pbus_sw_en_i    (pbus_sw_en_i),
  .flash_sw_en_i   (flash_sw_en_i),
  .flash_busy_i    (flash_busy_i),
  .apb_busy_i      (apb_busy_i),
  .wake_irq_i      (wake_irq_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .flash_clk_en_o  (flash_clk_en_o),
  .bridge_clk_en_o (bridge_clk_en_o),
  .pbus_clk_en_o   (pbus_clk_en_o),
  .pll_en_o        (pll_en_o),
  .xtal_en_o       (xtal_en_o),
  .core_pwr_en_o   (core_pwr_en_o),
  .sysclk_sel_o    (sysclk_sel_o),
  .state_q         (state_q)
);

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_APB = 8;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic mode_go_i, sel_load_i;
  logic [1:0] mode_sel_i, sel_req_i;
  logic flash_sw_en_i, ram_sw_en_i, pbus_sw_en_i, dma_sw_en_i;
  logic [N_APB-1:0] apb_periph_en_i;
  logic flash_busy_i, apb_busy_i, wake_irq_i, dbg_stop_hold_i, dbg_stdby_hold_i;
  logic cpu_clk_en_o, flash_clk_en_o, ram_clk_en_o, bridge_clk_en_o;
  logic pbus_clk_en_o, dma_clk_en_o, pll_en_o, rc_main_en_o, rc_14m_en_o;
  logic xtal_en_o, core_pwr_en_o;
  logic [1:0] sysclk_sel_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lpm_clk_ctrl #(.N_APB(N_APB)) dut_i (.*);

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [3:0] osc_all();
    return {pll_en_o, rc_main_en_o, rc_14m_en_o, xtal_en_o};
  endfunction

  function automatic logic [3:0] gates();
    return {cpu_clk_en_o, flash_clk_en_o, ram_clk_en_o, core_pwr_en_o};
  endfunction

  task automatic go_mode(logic [1:0] m);
    mode_sel_i = m; mode_go_i = 1'b1;
    step(1);
    mode_go_i = 1'b0;
  endtask

  task automatic pulse_reset();
    rst_ni = 1'b0;
    #2;
    chk("R1 gates", gates(), 4'hF);
    chk("R1 osc", osc_all(), 4'hF);
    chk("R1 sysclk", {2'b0, sysclk_sel_o}, 4'd0);
    step(1);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    chk("R1 gates", gates(), 4'hF);
    chk("R1 bus", {bridge_clk_en_o, pbus_clk_en_o, dma_clk_en_o, 1'b1}, 4'hF);
    chk("R1 osc", osc_all(), 4'hF);
    chk("R1 sysclk", {2'b0, sysclk_sel_o}, 4'd0);
  endtask

  task automatic t_sleep();
    sel_req_i = 2'd1; sel_load_i = 1'b1;
    step(1);
    sel_load_i = 1'b0;
    chk("R12 load in run", {2'b0, sysclk_sel_o}, 4'd1);
    flash_sw_en_i = 1'b0; ram_sw_en_i = 1'b1;
    go_mode(2'd1);
    chk("R2 sleep gates", gates(), 4'b0011);
    chk("R2 sleep osc", osc_all(), 4'hF);
    sel_req_i = 2'd2; sel_load_i = 1'b1;
    step(1);
    sel_load_i = 1'b0;
    chk("R12 load ignored", {2'b0, sysclk_sel_o}, 4'd1);
    flash_sw_en_i = 1'b1; ram_sw_en_i = 1'b0;
    step(1);
    chk("R2 sleep sw follow", gates(), 4'b0101);
    wake_irq_i = 1'b1;
    step(1);
    wake_irq_i = 1'b0; ram_sw_en_i = 1'b1;
    chk("R11 wake cpu", gates(), 4'b1111);
    chk("R11 sysclk kept", {2'b0, sysclk_sel_o}, 4'd1);
  endtask

  task automatic t_bridge();
    apb_periph_en_i = '0;
    step(1);
    chk("R3 bridge off", {3'b0, bridge_clk_en_o}, 4'd0);
    chk("R3 pbus kept", {3'b0, pbus_clk_en_o}, 4'd1);
    apb_periph_en_i = 8'h10;
    step(1);
    chk("R3 bridge on", {3'b0, bridge_clk_en_o}, 4'd1);
    apb_periph_en_i = '1;
  endtask

  task automatic t_swgate();
    pbus_sw_en_i = 1'b0; dma_sw_en_i = 1'b0;
    step(1);
    chk("R10 off", {2'b0, pbus_clk_en_o, dma_clk_en_o}, 4'd0);
    chk("R10 cpu kept", {3'b0, cpu_clk_en_o}, 4'd1);
    pbus_sw_en_i = 1'b1;
    step(1);
    chk("R10 pbus back", {2'b0, pbus_clk_en_o, dma_clk_en_o}, 4'b0010);
    dma_sw_en_i = 1'b1;
    step(1);
  endtask

  task automatic t_stop_flash_busy();
    flash_busy_i = 1'b1;
    go_mode(2'd2);
    chk("R5 pending", gates(), 4'hF);
    step(3);
    chk("R5 still pending", osc_all(), 4'hF);
    flash_busy_i = 1'b0;
    step(1);
    chk("R4 stop gates", gates(), 4'h0);
    chk("R4 stop osc", osc_all(), 4'h0);
    wake_irq_i = 1'b1;
    step(1);
    wake_irq_i = 1'b0;
    chk("R7 wake gates", gates(), 4'hF);
    chk("R7 wake osc", osc_all(), 4'hF);
    chk("R7 sysclk rc", {2'b0, sysclk_sel_o}, 4'd0);
  endtask

  task automatic t_stdby_apb_busy();
    sel_req_i = 2'd2; sel_load_i = 1'b1;
    step(1);
    sel_load_i = 1'b0;
    apb_busy_i = 1'b1;
    go_mode(2'd3);
    step(1);
    chk("R6 pending", {core_pwr_en_o, pll_en_o, cpu_clk_en_o, 1'b1}, 4'hF);
    apb_busy_i = 1'b0;
    step(1);
    chk("R4 stdby osc", osc_all(), 4'h0);
    chk("R4 stdby pwr", gates(), 4'h0);
    wake_irq_i = 1'b1;
    step(2);
    wake_irq_i = 1'b0;
    chk("R8 wake ignored", {core_pwr_en_o, cpu_clk_en_o, xtal_en_o, 1'b0}, 4'd0);
    chk("R8 sysclk kept", {2'b0, sysclk_sel_o}, 4'd2);
    pulse_reset();
  endtask

  task automatic t_dbg();
    dbg_stop_hold_i = 1'b1;
    go_mode(2'd2);
    step(1);
    chk("R9 stop held", gates(), 4'hF);
    chk("R9 stop osc", osc_all(), 4'hF);
    dbg_stop_hold_i = 1'b0;
    step(1);
    chk("R9 stop release", {core_pwr_en_o, 3'b0}, 4'd0);
    wake_irq_i = 1'b1;
    step(1);
    wake_irq_i = 1'b0;
    dbg_stdby_hold_i = 1'b1;
    go_mode(2'd3);
    step(1);
    chk("R9 stdby held", gates(), 4'hF);
    chk("R9 stdby osc", osc_all(), 4'hF);
    dbg_stdby_hold_i = 1'b0;
    pulse_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    mode_go_i = 1'b0; mode_sel_i = 2'd0; sel_load_i = 1'b0; sel_req_i = 2'd0;
    flash_sw_en_i = 1'b1; ram_sw_en_i = 1'b1; apb_periph_en_i = '1;
    pbus_sw_en_i = 1'b1; dma_sw_en_i = 1'b1; flash_busy_i = 1'b0; apb_busy_i = 1'b0;
    wake_irq_i = 1'b0; dbg_stop_hold_i = 1'b0; dbg_stdby_hold_i = 1'b0;
    step(2);
    t_reset();
    rst_ni = 1'b1;
    step(1);
    t_sleep();
    t_bridge();
    t_swgate();
    t_stop_flash_busy();
    t_stdby_apb_busy();
    t_dbg();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule